// File: doc/BRIEF.md
# Camera Interrupt Flag Register

This block is the interrupt register of a camera controller. A single 32-bit word holds three fields for up to eight interrupt sources: the pending flags, the per-source disable flags and a row of write-one-to-clear acknowledge strobes. Hardware event pulses from the capture logic set the pending flags. Source 0 carries the frame-boundary event, which the capture path raises once between consecutive camera frames. The other sources are general event inputs. All of them behave the same way inside this block.

Software reads the word to find out which sources are pending. It clears them by writing ones into the acknowledge field, and it masks sources through the disable field. Every pending flag whose source is not disabled is merged into one level-sensitive interrupt line. That line is registered before it leaves the block.

The port is a plain single-register interface. A write strobe with a data word updates the register. The read data always shows the current contents, with no read strobe needed.

Top module: `cam_irq_reg`

## Requirements
- R1: A one-cycle pulse on `evt_i[i]` sets pending flag i, which reads back at `rd_data_o[i]` (bits 0 to 7) from the cycle after the pulse. The flag stays set until it is acknowledged.
- R2: A write with a 1 in bit 16+i clears pending flag i. A write with a 0 in bit 16+i leaves pending flag i unchanged.
- R3: When an event pulse and an acknowledge for the same source fall in the same cycle, the flag ends up set.
- R4: Bits 0 to 7 of a write have no effect on the pending flags. A flag is set only by its event pulse.
- R5: A write loads bits 8 to 15 into the disable flags, which read back at `rd_data_o[15:8]`. A 1 in bit 8+i disables source i.
- R6: `rd_data_o[31:16]` always reads as zero, whatever was written to bits 16 to 31.
- R7: `irq_o` equals the OR over all sources of (pending AND NOT disabled), delayed by one register. It changes one cycle after the flags change.
- R8: A disabled source still records its pending flag. Clearing its disable bit later asserts `irq_o` one cycle after the mask change.
- R9: After reset, all pending flags are 0, all disable flags are 1 (`rd_data_o` = 0x0000FF00) and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data: disable flags in [15:8], acknowledge strobes in [23:16] |
| rd_data_o | output | 32 | Current register contents: pending flags in [7:0], disable flags in [15:8], zero above |
| evt_i | input | 8 | One-cycle event pulses, one per source; bit 0 is the frame-boundary event |
| irq_o | output | 1 | Registered level interrupt output |

## Verification
Each source is pulsed on its own to confirm that flags are independent and that each flag is held. All 256 pending patterns are then paired with a disable mask derived arithmetically from the pattern, which shows whether the output merge treats every bit position correctly. With all flags pending, a sweep over every disable mask isolates the masking path and the readback of the disable field. Targeted cases follow: an event colliding with its acknowledge, write data in the pending field, writes to the upper bits, and a pending flag released by clearing its disable bit.

// File: rtl/cam_irq_pkg.sv
package cam_irq_pkg;
    // Field layout of the register word as software decodes it
    localparam int unsigned REG_W   = 32;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned STAT_LO = 0;
    localparam int unsigned MASK_LO = STAT_LO + FIELD_W;
    localparam int unsigned ACK_LO  = MASK_LO + FIELD_W;
endpackage

// File: rtl/cam_irq_status.sv
module cam_irq_status #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] ack,
    output logic [N-1:0] stat_q
);
    typedef struct packed {
        logic [N-1:0] stat;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // event has priority over a same-cycle acknowledge
            if (evt[i])
                st_d.stat[i] = 1'b1;
            else if (ack[i])
                st_d.stat[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.stat;

    // R1
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
    // R1
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R2
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack & ~evt) != '0) |=> ((stat_q & $past(ack & ~evt)) == '0));
    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));
endmodule

// File: rtl/cam_irq_mask.sv
module cam_irq_mask #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wmask,
    output logic [N-1:0] mask_q
);
    typedef struct packed {
        logic [N-1:0] dis;
    } mask_state_t;

    mask_state_t ms_d, ms_q;

    always_comb begin
        ms_d = ms_q;
        if (wr_en) ms_d.dis = wmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ms_q <= '{dis: '1};
        else        ms_q <= ms_d;
    end

    assign mask_q = ms_q.dis;

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wmask)));
    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/cam_irq_merge.sv
module cam_irq_merge #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat,
    input  logic [N-1:0] mask,
    output logic         irq_q
);
    typedef struct packed {
        logic irq;
    } merge_state_t;

    merge_state_t mg_d, mg_q;
    logic [N-1:0] live;

    always_comb begin
        live   = stat & ~mask;
        mg_d   = mg_q;
        mg_d.irq = |live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mg_q <= '0;
        else        mg_q <= mg_d;
    end

    assign irq_q = mg_q.irq;

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~mask) == '0) |=> !irq_q);
    // R7 R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~mask) != '0) |=> irq_q);
endmodule

// File: rtl/cam_irq_reg.sv
module cam_irq_reg #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    input  logic [7:0]  evt_i,
    output logic        irq_o
);
    import cam_irq_pkg::*;

    localparam int unsigned N = (NUM_SRC > FIELD_W) ? FIELD_W : NUM_SRC;

    logic [N-1:0] stat_q, mask_q, ack;
    logic         wr_bits_unused;

    assign ack = wr_en_i ? wr_data_i[ACK_LO +: N] : '0;
    assign wr_bits_unused = ^{wr_data_i, evt_i};

    cam_irq_status #(.N(N)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_i[N-1:0]),
        .ack    (ack),
        .stat_q (stat_q)
    );

    cam_irq_mask #(.N(N)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_i),
        .wmask  (wr_data_i[MASK_LO +: N]),
        .mask_q (mask_q)
    );

    cam_irq_merge #(.N(N)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat_q),
        .mask  (mask_q),
        .irq_q (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        rd_data_o[STAT_LO +: N] = stat_q;
        rd_data_o[MASK_LO +: N] = mask_q;
    end

    // R6
    always_comb begin
        upper_zero_chk: assert (rd_data_o[31:16] == 16'h0);
    end
endmodule

// File: tb/sim_cam_irq_reg.sv
module sim_cam_irq_reg;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  evt = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cam_irq_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata),
        .rd_data_o(rdata), .evt_i(evt), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // advance one edge; inputs set before the call are taken at that edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [7:0] ackb, input logic [7:0] dis, input logic [7:0] low);
        wdata = {8'h00, ackb, dis, low};
        wr_en = 1'b1;
        step();
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic pulse(input logic [7:0] e);
        evt = e;
        step();
        evt = '0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] m;
        repeat (3) step();
        // R9 reset state
        check("R9 reset word", rdata, 32'h0000FF00);
        check("R9 reset irq", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        step();

        // R1 R8 each source alone, while disabled
        for (int i = 0; i < 8; i++) begin
            pulse(8'h01 << i);
            check("R1 flag set", rdata, 32'h0000FF00 | (32'h1 << i));
            step(); step();
            check("R1 flag held", rdata, 32'h0000FF00 | (32'h1 << i));
            check("R8 disabled no irq", {31'h0, irq}, 32'h0);
            reg_write(8'h00, ~(8'h01 << i), 8'h00);
            check("R8 pending kept after enable", rdata[7:0], 32'h1 << i);
            step();
            check("R8 irq after enable", {31'h0, irq}, 32'h1);
            reg_write(8'h01 << i, 8'hFF, 8'h00);
            check("R2 ack clears", rdata, 32'h0000FF00);
            step();
            check("R7 irq drops", {31'h0, irq}, 32'h0);
        end

        // R7 every pending pattern with a derived mask
        for (int p = 0; p < 256; p++) begin
            m = 8'(p * 37 + 91);
            reg_write(8'hFF, m, 8'h00);
            pulse(8'(p));
            check("R7 pattern readback", rdata, {16'h0, m, 8'(p)});
            check("R7 irq lags one cycle", {31'h0, irq}, 32'h0);
            step();
            check("R7 irq merge", {31'h0, irq}, {31'h0, |(8'(p) & ~m)});
        end

        // R5 every mask with all flags pending
        pulse(8'hFF);
        for (int k = 0; k < 256; k++) begin
            reg_write(8'h00, 8'(k), 8'h00);
            check("R5 mask readback", rdata, {16'h0, 8'(k), 8'hFF});
            step();
            check("R5 mask effect", {31'h0, irq}, {31'h0, (8'(k) != 8'hFF)});
        end

        // R2 partial ack leaves others
        reg_write(8'h5A, 8'h00, 8'h00);
        check("R2 partial ack", rdata[7:0], 32'hA5);

        // R3 event wins over ack in same cycle
        reg_write(8'hFF, 8'hFF, 8'h00);
        evt = 8'h81;
        reg_write(8'h81, 8'hFF, 8'h00);
        evt = '0;
        check("R3 event beats ack", rdata[7:0], 32'h81);

        // R4 write data in the pending field is ignored
        reg_write(8'hFF, 8'hFF, 8'h00);
        reg_write(8'h00, 8'h00, 8'hFF);
        check("R4 write cannot set", rdata, 32'h00000000);
        step();
        check("R4 no irq from write", {31'h0, irq}, 32'h0);

        // R6 upper bits read zero after writing ones there
        pulse(8'h3C);
        wdata = 32'hFF00_0F00;
        wr_en = 1'b1;
        step();
        wr_en = 1'b0;
        check("R6 upper zero", rdata, 32'h00000F3C);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule